// File: doc/BRIEF.md
# LED Matrix Fault Detection Sequencer

This block runs a one-shot open or short test over a four-row by eighteen-column LED matrix. Software arms it by moving a 2-bit detection field from 00 to a nonzero code. The block then waits for the scanner to begin a new frame. Over the next two complete frames it samples a per-column fault comparator during every active row slot. At the end of the second frame it commits the results into twelve status bytes in a single cycle.

The scanner supplies three things: a one-cycle strobe for each row slot, the index of the row in that slot, and the index of the last row that the current scan mode drives. The comparator supplies one fault bit per column, and that bit is valid while the strobe is high. A per-dot skip vector marks dots whose scaling is zero. A mode output tells the comparator whether it should look for opens or shorts. A busy flag is high while a run is in progress.

Top module: `led_fault_scan`

## Requirements
- R1: After reset, every status byte reads 0x00, busy is low and the short-mode output is low.
- R2: A run starts only on the clock edge where the detection field was 00 in the previous cycle and is nonzero now, while no run is in progress. A field held nonzero, or changed from one nonzero code to another, starts nothing and leaves every status byte unchanged.
- R3: The short-mode output goes high when a run starts with code 10. It goes low when a run starts with code 01 or 11. It holds that value for the whole run.
- R4: Busy rises on the clock edge that starts the run and stays high until the edge that commits the results.
- R5: Row slots strobed before the first slot of row 0 are ignored. Two full frames follow, each running from row 0 to the last active row. On the edge that samples the last row of the second frame, busy falls and results are committed. A dot's result bit is 1 only if its column's fault input was 1 in both frames.
- R6: Status byte index 3*r+g, for r = 0..3 and g = 0..2, holds row r. Its bits 5:0 hold columns 6g+5 down to 6g. Bits 7:6 always read 0. The bytes are packed on status output bits [8k+7:8k].
- R7: A dot whose skip bit (index row*18+column) is 1 at commit time keeps its previous status bit.
- R8: Rows above the last active row are neither sampled nor committed, and they keep their previous bits. Slots strobed with such a row index are ignored.
- R9: Status bytes do not change while a run is in progress. They change only on the commit edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| det_en_i | input | 2 | Detection field: 00 off, 01/11 open, 10 short |
| last_row_i | input | 2 | Index of the last row driven by the scan mode |
| row_slot_i | input | 1 | One-cycle strobe; fault input valid for this row slot |
| row_idx_i | input | 2 | Row of the current slot |
| fault_i | input | 18 | Per-column comparator result |
| skip_i | input | 72 | Per-dot skip (zero scaling), bit row*18+column |
| busy_o | output | 1 | Run in progress |
| short_o | output | 1 | Comparator mode: 1 short, 0 open |
| status_o | output | 96 | Twelve status bytes |

## Verification
The bench builds the block with its default parameters: four rows, eighteen columns and six columns per byte. At that size every combination of scan depth (one to four active rows) and detection code (01, 10, 11) can be run in turn. Each run starts mid-frame, injects stray slots for inactive rows, and applies a skip pattern that changes from run to run. As a result, the two-frame AND, the row and skip retention and the byte packing are all checked against an arithmetic model across the whole status map.

// File: rtl/led_fault_scan.sv
module led_fault_scan #(
  parameter int ROWS = 4,
  parameter int COLS = 18,
  parameter int GRP  = 6
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [1:0]                         det_en_i,
  input  logic [$clog2(ROWS)-1:0]            last_row_i,
  input  logic                               row_slot_i,
  input  logic [$clog2(ROWS)-1:0]            row_idx_i,
  input  logic [COLS-1:0]                    fault_i,
  input  logic [ROWS*COLS-1:0]               skip_i,
  output logic                               busy_o,
  output logic                               short_o,
  output logic [ROWS*(COLS/GRP)*8-1:0]       status_o
);
  localparam int NG = COLS / GRP;

  typedef enum logic [1:0] {IDLE, SYNC, RUN} st_t;

  st_t             st;
  logic [1:0]      en_q;
  logic            fcnt;
  logic            short_q;
  logic [COLS-1:0] acc   [ROWS];
  logic [COLS-1:0] acc_n [ROWS];
  logic [COLS-1:0] stat  [ROWS];
  logic [ROWS-1:0] tch, tch_n;

  wire trig = (en_q == 2'b00) && (det_en_i != 2'b00) && (st == IDLE);
  wire samp = row_slot_i && (row_idx_i <= last_row_i) &&
              (st == RUN || (st == SYNC && row_idx_i == '0));
  wire fend = samp && (row_idx_i == last_row_i);

  assign busy_o  = (st != IDLE);
  assign short_o = short_q;

  always_comb begin
    acc_n = acc;
    tch_n = tch;
    if (samp) begin
      if (!fcnt) acc_n[row_idx_i] = fault_i;
      else begin
        acc_n[row_idx_i] = acc[row_idx_i] & fault_i;
        tch_n[row_idx_i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      en_q    <= 2'b00;
      fcnt    <= 1'b0;
      short_q <= 1'b0;
      tch     <= '0;
      for (int r = 0; r < ROWS; r++) begin
        acc[r]  <= '0;
        stat[r] <= '0;
      end
    end else begin
      en_q <= det_en_i;
      if (trig) begin
        st      <= SYNC;
        fcnt    <= 1'b0;
        tch     <= '0;
        short_q <= (det_en_i == 2'b10);
      end else if (samp) begin
        acc <= acc_n;
        tch <= tch_n;
        if (fend && fcnt) begin
          st <= IDLE;
          for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
              if (tch_n[r] && !skip_i[r*COLS+c]) stat[r][c] <= acc_n[r][c];
        end else begin
          st <= RUN;
          if (fend) fcnt <= 1'b1;
        end
      end
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar g = 0; g < NG; g++) begin : g_byte
      assign status_o[(r*NG+g)*8 +: 8] = {{(8-GRP){1'b0}}, stat[r][g*GRP +: GRP]};
    end
  end

  p_busy_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ($past(det_en_i) != 2'b00 && $past(en_q) == 2'b00));

  p_busy_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(row_slot_i && row_idx_i == last_row_i));

  p_mode_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(short_o));

  p_stat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(busy_o) |-> $stable(status_o));
endmodule

// File: tb/led_fault_scan_tb.sv
module led_fault_scan_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  det_en = 2'b00;
  logic [1:0]  last_row = 2'd0;
  logic        row_slot = 1'b0;
  logic [1:0]  row_idx = 2'd0;
  logic [17:0] fault = '0;
  logic [71:0] skip = '0;
  logic        busy, short_m;
  logic [95:0] status;

  int total = 0;
  int fails = 0;
  logic [17:0] exp_row [4];

  always #(CLK_P/2) clk = ~clk;

  led_fault_scan dut_i (
    .clk(clk), .rst_n(rst_n), .det_en_i(det_en), .last_row_i(last_row),
    .row_slot_i(row_slot), .row_idx_i(row_idx), .fault_i(fault), .skip_i(skip),
    .busy_o(busy), .short_o(short_m), .status_o(status));

  function automatic logic [17:0] pat(int run, int r, int k);
    int v;
    v = run*7919 + r*104729 + k*1299709;
    v = v*1103515245 + 12345;
    return v[25:8];
  endfunction

  function automatic logic [71:0] skipf(int run);
    logic [71:0] s = '0;
    for (int i = 0; i < 72; i++) if ((i*3 + run) % 7 == 0) s[i] = 1'b1;
    return s;
  endfunction

  function automatic logic [95:0] exp_vec();
    logic [95:0] v = '0;
    for (int r = 0; r < 4; r++)
      for (int g = 0; g < 3; g++)
        v[(r*3+g)*8 +: 8] = {2'b00, exp_row[r][g*6 +: 6]};
    return v;
  endfunction

  task automatic chk(bit ok, string tag, logic [95:0] act, logic [95:0] expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic slot(int r, logic [17:0] f);
    @(negedge clk);
    row_idx = r[1:0];
    fault = f;
    row_slot = 1'b1;
    @(negedge clk);
    row_slot = 1'b0;
  endtask

  task automatic do_run(int run, logic [1:0] mode, int lr);
    logic [95:0] ev;
    @(negedge clk);
    det_en = 2'b00;
    last_row = lr[1:0];
    skip = skipf(run);
    repeat (2) @(negedge clk);
    det_en = mode;
    @(negedge clk);
    chk(busy == 1'b1, "R4 busy after trigger", 96'(busy), 96'd1);
    chk(short_m == (mode == 2'b10), "R3 short mode", 96'(short_m), 96'(mode == 2'b10));
    for (int r = 1; r <= lr; r++) slot(r, '1);
    ev = exp_vec();
    for (int r = 0; r <= lr; r++) begin
      slot(r, pat(run, r, 1));
      if (r == 0 && lr < 3) slot(lr + 1, '1);
    end
    chk(busy == 1'b1 && status == ev, "R9 hold during run", status, ev);
    for (int r = 0; r <= lr; r++) slot(r, pat(run, r, 2));
    chk(busy == 1'b0, "R5 busy falls at commit", 96'(busy), 96'd0);
    for (int r = 0; r <= lr; r++)
      for (int c = 0; c < 18; c++)
        if (!skip[r*18+c]) exp_row[r][c] = pat(run, r, 1)[c] & pat(run, r, 2)[c];
    ev = exp_vec();
    for (int b = 0; b < 12; b++)
      chk(status[b*8 +: 8] == ev[b*8 +: 8], $sformatf("R5 R6 R7 R8 byte %0d", b),
          96'(status[b*8 +: 8]), 96'(ev[b*8 +: 8]));
    @(negedge clk);
    det_en = (mode == 2'b01) ? 2'b11 : 2'b01;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0 && status == ev, "R2 no start without 00", status, ev);
  endtask

  initial begin
    for (int r = 0; r < 4; r++) exp_row[r] = '0;
    repeat (3) @(negedge clk);
    chk(status == '0 && busy == 1'b0 && short_m == 1'b0, "R1 reset state",
        {status[93:0], busy, short_m}, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int lr = 0; lr < 4; lr++)
      for (int m = 1; m < 4; m++)
        do_run(lr*3 + m, m[1:0], lr);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule